// File: doc/BRIEF.md
# Field-Width Aware Integer ALU

This is the combinational execution unit of a small 32-bit controller core whose register operands can be narrow sub-fields of a register: one of four bytes, one of three overlapping 16-bit halves, or the whole word. Each of the two source operands arrives as a raw 32-bit register value. It comes with a width code and an index that pick the field. The unit extracts that field and zero-extends it to 32 bits. It then applies the requested operation and truncates the outcome to the destination field width.

Arithmetic is evaluated on 33 bits. The new carry is the bit that sits just above the destination width, so the same adder serves 8-, 16- and 32-bit destinations. Non-arithmetic operations leave the stored carry as it is. The unit has no state. The register file supplies the fields and stores the result and carry afterwards.

Top module: `fwalu_top`

## Requirements
- R1: A width code selects the source field: 0 is a byte, 1 is a 16-bit half and 2 or 3 is the full word. For a byte, index k selects bits 8k+7..8k. For a half, index k selects bits 8k+15..8k, so halves overlap by one byte; half index 3 yields only bits 31..24. For the full word the index is ignored. The field is zero-extended to 32 bits.
- R2: The result carries no bits above the destination width, which uses the same code as R1. Opcode 0 (add) returns a+b, and the carry is bit 8, 16 or 32 of the 33-bit sum for a byte, half or word destination.
- R3: Opcode 1 (add with carry) adds the carry input to a+b, and its carry is taken as in R2.
- R4: Opcode 2 returns a-b and opcode 3 returns a-b-carry_in. The carry is the bit above the destination width of the 33-bit two's-complement difference, so it is 1 when an in-range subtraction borrows.
- R5: Opcode 4 returns b-a and opcode 5 returns b-a-carry_in. The carry is taken as in R4.
- R6: Opcode 6 shifts a left and opcode 7 shifts a right, both logically, by b[4:0] only.
- R7: Opcodes 8, 9 and 10 return a AND b, a OR b and a XOR b. Opcode 11 returns NOT a.
- R8: Opcode 12 returns b only when b < a and otherwise returns a. Opcode 13 returns b only when b > a and otherwise returns a.
- R9: Opcode 14 clears bit b[4:0] of a and opcode 15 sets it.
- R10: Opcode 16 scans a downward, starting at the top bit of a's source field, for a bit equal to b[0]. It returns the index of the first match, or 32 when no bit matches.
- R11: Opcodes 17 to 31 return zero and pass carry_in to carry_out.
- R12: Opcodes 6 to 16 pass carry_in to carry_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_val | input | 32 | Register holding operand a |
| src_a_fw | input | 2 | Field width code of operand a |
| src_a_sel | input | 2 | Field index of operand a |
| src_b_val | input | 32 | Register holding operand b |
| src_b_fw | input | 2 | Field width code of operand b |
| src_b_sel | input | 2 | Field index of operand b |
| dst_fw | input | 2 | Destination field width code |
| op | input | 5 | Operation code |
| carry_in | input | 1 | Stored carry flag |
| result | output | 32 | Result, zero above the destination width |
| carry_out | output | 1 | New carry flag |

## Verification
Some properties are checked on every evaluation of the unit. The extracted fields and the result never spill above their widths. A non-arithmetic operation never alters the carry. A minimum never exceeds either operand. Any index reported by the bit scan lies inside the source field and points at a bit of the requested value. The scenarios alone can show that the values themselves are correct. These include the carry position for each destination width, the overlap of the halves, shift amounts above 31, ties in min and max, and the no-match value of 32.

// File: rtl/fwalu_pkg.sv
package fwalu_pkg;

  localparam int XLEN    = 32;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int SEL_W   = $clog2(XLEN / BYTE_W);
  localparam int SHAMT_W = $clog2(XLEN);
  localparam int CNT_W   = SHAMT_W + 1;

  typedef enum logic [1:0] {
    FW_BYTE = 2'd0,
    FW_HALF = 2'd1,
    FW_FULL = 2'd2,
    FW_WIDE = 2'd3
  } fwidth_e;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBB = 5'd3,
    OP_RSUB = 5'd4,  OP_RSBB = 5'd5,  OP_SHL  = 5'd6,  OP_SHR  = 5'd7,
    OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_INV  = 5'd11,
    OP_MIN  = 5'd12, OP_MAX  = 5'd13, OP_BCLR = 5'd14, OP_BSET = 5'd15,
    OP_LMSB = 5'd16
  } alu_op_e;

  function automatic logic [XLEN-1:0] width_mask(fwidth_e fw);
    case (fw)
      FW_BYTE: width_mask = XLEN'({BYTE_W{1'b1}});
      FW_HALF: width_mask = XLEN'({HALF_W{1'b1}});
      default: width_mask = {XLEN{1'b1}};
    endcase
  endfunction

  function automatic int width_bits(fwidth_e fw);
    case (fw)
      FW_BYTE: width_bits = BYTE_W;
      FW_HALF: width_bits = HALF_W;
      default: width_bits = XLEN;
    endcase
  endfunction

endpackage

// File: rtl/fwalu_field_pick.sv
module fwalu_field_pick
  import fwalu_pkg::*;
(
  input  logic [XLEN-1:0]  reg_val,
  input  fwidth_e          fw,
  input  logic [SEL_W-1:0] sel,
  output logic [XLEN-1:0]  field
);
  logic [XLEN-1:0] shifted;

  always_comb begin
    shifted = reg_val >> {sel, 3'b000};
    case (fw)
      FW_BYTE, FW_HALF: field = shifted & width_mask(fw);
      default:          field = reg_val;
    endcase
  end

  // R1: the extracted field never reaches above its width
  always_comb begin
    a_r1_field_fits: assert ((field & ~width_mask(fw)) == '0);
  end

endmodule

// File: rtl/fwalu_arith.sv
module fwalu_arith
  import fwalu_pkg::*;
(
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_op_e         opc,
  input  logic            cin,
  input  fwidth_e         dst_fw,
  output logic            hit,
  output logic [XLEN-1:0] sum,
  output logic            cout
);
  logic [XLEN:0] ea, eb, ec, t;

  always_comb begin
    ea  = {1'b0, opa};
    eb  = {1'b0, opb};
    ec  = {{XLEN{1'b0}}, cin};
    hit = 1'b1;
    case (opc)
      OP_ADD:  t = ea + eb;
      OP_ADDC: t = ea + eb + ec;
      OP_SUB:  t = ea - eb;
      OP_SUBB: t = ea - eb - ec;
      OP_RSUB: t = eb - ea;
      OP_RSBB: t = eb - ea - ec;
      default: begin
        t   = '0;
        hit = 1'b0;
      end
    endcase
    sum = t[XLEN-1:0];
    case (dst_fw)
      FW_BYTE: cout = t[BYTE_W];
      FW_HALF: cout = t[HALF_W];
      default: cout = t[XLEN];
    endcase
  end

endmodule

// File: rtl/fwalu_logic.sv
module fwalu_logic
  import fwalu_pkg::*;
(
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_op_e         opc,
  output logic            hit,
  output logic [XLEN-1:0] y
);
  logic [SHAMT_W-1:0] amt;
  logic [XLEN-1:0]    onehot;

  always_comb begin
    amt    = opb[SHAMT_W-1:0];
    onehot = XLEN'(1) << amt;
    hit    = 1'b1;
    case (opc)
      OP_SHL:  y = opa << amt;
      OP_SHR:  y = opa >> amt;
      OP_AND:  y = opa & opb;
      OP_OR:   y = opa | opb;
      OP_XOR:  y = opa ^ opb;
      OP_INV:  y = ~opa;
      OP_MIN:  y = (opb < opa) ? opb : opa;
      OP_MAX:  y = (opb > opa) ? opb : opa;
      OP_BCLR: y = opa & ~onehot;
      OP_BSET: y = opa | onehot;
      default: begin
        y   = '0;
        hit = 1'b0;
      end
    endcase
  end

  // R8: a minimum never exceeds either operand
  always_comb begin
    if (opc == OP_MIN) begin
      a_r8_min_bound: assert (y <= opa && y <= opb);
    end
  end

endmodule

// File: rtl/fwalu_lmsb.sv
module fwalu_lmsb
  import fwalu_pkg::*;
(
  input  logic [XLEN-1:0]  opa,
  input  fwidth_e          src_fw,
  input  logic             want,
  output logic [CNT_W-1:0] idx
);
  int top_w;

  always_comb begin
    top_w = width_bits(src_fw);
    idx   = CNT_W'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (i < top_w && opa[i] == want) idx = CNT_W'(i);
    end
  end

  // R10: a reported index lies in the field and holds the wanted value
  always_comb begin
    if (idx != CNT_W'(XLEN)) begin
      a_r10_scan_hit: assert (int'(idx) < top_w && opa[idx[SHAMT_W-1:0]] == want);
    end
  end

endmodule

// File: rtl/fwalu_top.sv
module fwalu_top
  import fwalu_pkg::*;
(
  input  logic [31:0] src_a_val,
  input  logic [1:0]  src_a_fw,
  input  logic [1:0]  src_a_sel,
  input  logic [31:0] src_b_val,
  input  logic [1:0]  src_b_fw,
  input  logic [1:0]  src_b_sel,
  input  logic [1:0]  dst_fw,
  input  logic [4:0]  op,
  input  logic        carry_in,
  output logic [31:0] result,
  output logic        carry_out
);
  localparam int NSRC = 2;

  logic [XLEN-1:0]  raw_v [NSRC];
  fwidth_e          fw_v  [NSRC];
  logic [SEL_W-1:0] sel_v [NSRC];
  logic [XLEN-1:0]  fld_v [NSRC];

  alu_op_e          opc;
  fwidth_e          dfw;
  logic             ar_hit, lg_hit, ar_c;
  logic [XLEN-1:0]  ar_y, lg_y, pre_y;
  logic [CNT_W-1:0] scan_idx;

  always_comb begin
    raw_v[0] = src_a_val;
    raw_v[1] = src_b_val;
    fw_v[0]  = fwidth_e'(src_a_fw);
    fw_v[1]  = fwidth_e'(src_b_fw);
    sel_v[0] = src_a_sel;
    sel_v[1] = src_b_sel;
    opc      = alu_op_e'(op);
    dfw      = fwidth_e'(dst_fw);
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    fwalu_field_pick u_pick (
      .reg_val (raw_v[s]),
      .fw      (fw_v[s]),
      .sel     (sel_v[s]),
      .field   (fld_v[s])
    );
  end

  fwalu_arith u_arith (
    .opa(fld_v[0]), .opb(fld_v[1]), .opc(opc), .cin(carry_in),
    .dst_fw(dfw), .hit(ar_hit), .sum(ar_y), .cout(ar_c)
  );

  fwalu_logic u_logic (
    .opa(fld_v[0]), .opb(fld_v[1]), .opc(opc), .hit(lg_hit), .y(lg_y)
  );

  fwalu_lmsb u_lmsb (
    .opa(fld_v[0]), .src_fw(fw_v[0]), .want(fld_v[1][0]), .idx(scan_idx)
  );

  always_comb begin
    if (ar_hit)              pre_y = ar_y;
    else if (lg_hit)         pre_y = lg_y;
    else if (opc == OP_LMSB) pre_y = XLEN'(scan_idx);
    else                     pre_y = '0;
    result    = pre_y & width_mask(dfw);
    carry_out = ar_hit ? ar_c : carry_in;
  end

  // R2: the result is confined to the destination field
  // R12: units other than the adder never alter the carry
  // R11: opcodes with no unit behind them give zero
  always_comb begin
    a_r2_dst_fits: assert ((result & ~width_mask(dfw)) == '0);
    if (!ar_hit) begin
      a_r12_carry_kept: assert (carry_out == carry_in);
    end
    if (!ar_hit && !lg_hit && opc != OP_LMSB) begin
      a_r11_idle_zero: assert (result == '0);
    end
  end

endmodule

// File: tb/tb_fwalu_top.sv
module tb_fwalu_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a_val, b_val, result;
  logic [1:0]  a_fw, a_sel, b_fw, b_sel, d_fw;
  logic [4:0]  op;
  logic        cin, cout;

  fwalu_top dut (
    .src_a_val(a_val), .src_a_fw(a_fw), .src_a_sel(a_sel),
    .src_b_val(b_val), .src_b_fw(b_fw), .src_b_sel(b_sel),
    .dst_fw(d_fw), .op(op), .carry_in(cin),
    .result(result), .carry_out(cout)
  );

  typedef struct {
    logic [31:0] res;
    logic        c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  function automatic logic [31:0] pick(logic [31:0] r, logic [1:0] fw, logic [1:0] k);
    if (fw == 2'd0) begin
      case (k)
        2'd0: return {24'd0, r[7:0]};
        2'd1: return {24'd0, r[15:8]};
        2'd2: return {24'd0, r[23:16]};
        default: return {24'd0, r[31:24]};
      endcase
    end else if (fw == 2'd1) begin
      case (k)
        2'd0: return {16'd0, r[15:0]};
        2'd1: return {16'd0, r[23:8]};
        2'd2: return {16'd0, r[31:16]};
        default: return {24'd0, r[31:24]};
      endcase
    end
    return r;
  endfunction

  function automatic int bits_of(logic [1:0] fw);
    return (fw == 2'd0) ? 8 : (fw == 2'd1) ? 16 : 32;
  endfunction

  function automatic string req_of(logic [4:0] o);
    case (o)
      5'd0: return "R2";
      5'd1: return "R3";
      5'd2, 5'd3: return "R4";
      5'd4, 5'd5: return "R5";
      5'd6, 5'd7: return "R6";
      5'd8, 5'd9, 5'd10, 5'd11: return "R7";
      5'd12, 5'd13: return "R8";
      5'd14, 5'd15: return "R9";
      5'd16: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [31:0] av, input logic [1:0] afw, input logic [1:0] asl,
                       input logic [31:0] bv, input logic [1:0] bfw, input logic [1:0] bsl,
                       input logic [1:0] dfw, input logic [4:0] o, input logic ci,
                       output logic [31:0] r, output logic c);
    longint unsigned a, b, k, t, m33;
    int w, sw, found;
    a   = pick(av, afw, asl);
    b   = pick(bv, bfw, bsl);
    k   = ci;
    w   = bits_of(dfw);
    m33 = 64'h1_FFFF_FFFF;
    c   = ci;
    t   = 0;
    case (o)
      5'd0: t = (a + b) & m33;
      5'd1: t = (a + b + k) & m33;
      5'd2: t = (a - b) & m33;
      5'd3: t = (a - b - k) & m33;
      5'd4: t = (b - a) & m33;
      5'd5: t = (b - a - k) & m33;
      5'd6: t = (a << (b % 32)) & 64'hFFFF_FFFF;
      5'd7: t = a >> (b % 32);
      5'd8: t = a & b;
      5'd9: t = a | b;
      5'd10: t = a ^ b;
      5'd11: t = ~a & 64'hFFFF_FFFF;
      5'd12: t = (b < a) ? b : a;
      5'd13: t = (b > a) ? b : a;
      5'd14: t = a & ~(64'd1 << (b % 32));
      5'd15: t = a | (64'd1 << (b % 32));
      5'd16: begin
        sw = bits_of(afw);
        found = 32;
        for (int i = sw - 1; i >= 0; i--) begin
          if (((a >> i) & 1) == (b & 1)) begin
            found = i;
            break;
          end
        end
        t = longint'(found);
      end
      default: t = 0;
    endcase
    if (o <= 5'd5) c = t[w];
    r = 32'(t & ((64'd1 << w) - 1));
  endtask

  task automatic apply(input logic [31:0] av, input logic [1:0] afw, input logic [1:0] asl,
                       input logic [31:0] bv, input logic [1:0] bfw, input logic [1:0] bsl,
                       input logic [1:0] dfw, input logic [4:0] o, input logic ci);
    @(negedge clk);
    a_val = av; a_fw = afw; a_sel = asl;
    b_val = bv; b_fw = bfw; b_sel = bsl;
    d_fw = dfw; op = o; cin = ci;
  endtask

  // Drive and predict through the model
  task automatic send(input logic [31:0] av, input logic [1:0] afw, input logic [1:0] asl,
                      input logic [31:0] bv, input logic [1:0] bfw, input logic [1:0] bsl,
                      input logic [1:0] dfw, input logic [4:0] o, input logic ci);
    exp_t e;
    apply(av, afw, asl, bv, bfw, bsl, dfw, o, ci);
    model(av, afw, asl, bv, bfw, bsl, dfw, o, ci, e.res, e.c);
    e.tag = req_of(o);
    exp_q.push_back(e);
  endtask

  // Drive with a hand-computed expectation
  task automatic send_x(input logic [31:0] av, input logic [1:0] afw, input logic [1:0] asl,
                        input logic [31:0] bv, input logic [1:0] bfw, input logic [1:0] bsl,
                        input logic [1:0] dfw, input logic [4:0] o, input logic ci,
                        input logic [31:0] er, input logic ec, input string tag);
    exp_t e;
    apply(av, afw, asl, bv, bfw, bsl, dfw, o, ci);
    e.res = er; e.c = ec; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare at the rising edge, half a period after driving
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (result !== e.res || cout !== e.c) begin
        bad++;
        $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                 e.tag, result, cout, e.res, e.c);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_val = '0; b_val = '0; a_fw = '0; a_sel = '0; b_fw = '0; b_sel = '0;
    d_fw = 2'd2; op = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state with zero inputs
    send_x(0, 2, 0, 0, 2, 0, 2, 5'd0, 0, 32'h0, 1'b0, "R2 reset");
    // R1 field picks
    send_x(32'hAABBCCDD, 0, 2, 0, 2, 0, 2, 5'd0, 0, 32'h000000BB, 1'b0, "R1 byte2");
    send_x(32'hAABBCCDD, 1, 1, 0, 2, 0, 2, 5'd0, 0, 32'h0000BBCC, 1'b0, "R1 half1");
    send_x(32'hAABBCCDD, 1, 3, 0, 2, 0, 2, 5'd0, 0, 32'h000000AA, 1'b0, "R1 half3");
    send_x(32'hAABBCCDD, 3, 1, 0, 2, 0, 2, 5'd0, 0, 32'hAABBCCDD, 1'b0, "R1 full");
    // R2 carry position
    send_x(32'hFF, 0, 0, 32'h1, 0, 0, 0, 5'd0, 0, 32'h0, 1'b1, "R2 byte carry");
    send_x(32'hFF, 0, 0, 32'h1, 0, 0, 1, 5'd0, 0, 32'h100, 1'b0, "R2 half dst");
    send_x(32'hFFFF_FFFF, 2, 0, 32'h1, 2, 0, 2, 5'd0, 0, 32'h0, 1'b1, "R2 word carry");
    // R3
    send_x(32'hFE, 0, 0, 32'h1, 0, 0, 0, 5'd1, 1, 32'h0, 1'b1, "R3 adc");
    // R4 borrow
    send_x(32'h5, 0, 0, 32'h7, 0, 0, 0, 5'd2, 0, 32'hFE, 1'b1, "R4 sub borrow");
    send_x(32'h7, 0, 0, 32'h5, 0, 0, 0, 5'd3, 1, 32'h1, 1'b0, "R4 subb");
    // R5 reverse
    send_x(32'h3, 2, 0, 32'h10, 2, 0, 2, 5'd4, 0, 32'hD, 1'b0, "R5 rsub");
    send_x(32'h10, 1, 0, 32'h10, 1, 0, 1, 5'd5, 1, 32'hFFFF, 1'b1, "R5 rsbb");
    // R6 shift uses low 5 bits
    send_x(32'h1, 2, 0, 32'd33, 2, 0, 2, 5'd6, 0, 32'h2, 1'b0, "R6 shl 33");
    send_x(32'h8000_0000, 2, 0, 32'd31, 2, 0, 2, 5'd7, 1, 32'h1, 1'b1, "R6 shr");
    // R7
    send_x(32'hF0F0, 2, 0, 32'h0FF0, 2, 0, 2, 5'd10, 0, 32'hFF00, 1'b0, "R7 xor");
    send_x(32'h0, 2, 0, 32'h0, 2, 0, 0, 5'd11, 0, 32'hFF, 1'b0, "R7 not byte");
    // R8 ties and order
    send_x(32'h9, 2, 0, 32'h9, 2, 0, 2, 5'd12, 0, 32'h9, 1'b0, "R8 min tie");
    send_x(32'h9, 2, 0, 32'h4, 2, 0, 2, 5'd12, 0, 32'h4, 1'b0, "R8 min");
    send_x(32'h9, 2, 0, 32'h4, 2, 0, 2, 5'd13, 0, 32'h9, 1'b0, "R8 max");
    // R9
    send_x(32'hFFFF_FFFF, 2, 0, 32'd36, 2, 0, 2, 5'd14, 0, 32'hFFFF_FFEF, 1'b0, "R9 clr");
    send_x(32'h0, 2, 0, 32'd31, 2, 0, 2, 5'd15, 1, 32'h8000_0000, 1'b1, "R9 set");
    // R10 scan
    send_x(32'h0, 0, 0, 32'h1, 2, 0, 2, 5'd16, 0, 32'd32, 1'b0, "R10 none");
    send_x(32'h10, 0, 0, 32'h1, 2, 0, 2, 5'd16, 0, 32'd4, 1'b0, "R10 one");
    send_x(32'hFFFF_FF7F, 0, 0, 32'h0, 2, 0, 2, 5'd16, 0, 32'd7, 1'b0, "R10 byte top");
    send_x(32'hFFFF_FFFF, 2, 0, 32'h0, 2, 0, 2, 5'd16, 1, 32'd32, 1'b1, "R10 full none");
    // R11 unused opcodes
    send_x(32'h1234, 2, 0, 32'h1, 2, 0, 2, 5'd17, 1, 32'h0, 1'b1, "R11 op17");
    send_x(32'h1234, 2, 0, 32'h1, 2, 0, 2, 5'd31, 0, 32'h0, 1'b0, "R11 op31");
    // R12 carry passes through non-arithmetic operations
    send_x(32'hFF, 0, 0, 32'hFF, 0, 0, 0, 5'd9, 1, 32'hFF, 1'b1, "R12 or");

    for (int n = 0; n < 400; n++) begin
      send($urandom, 2'($urandom), 2'($urandom), $urandom, 2'($urandom), 2'($urandom),
           2'($urandom), 5'($urandom_range(0, 20)), 1'($urandom));
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule